// File: doc/BRIEF.md
# Host Bus DMA Master Sequencer

This block performs direct memory access transactions as bus master on a 32-bit host bus. It acts for internal transmit and receive engines. An engine hands over a request that carries a start address, a direction and one of three burst lengths. The sequencer asks for bus ownership, but only while no slave access to the chip is in progress. Once it is granted the bus, it drives the address on the shared data lines together with the size and direction codes. It then moves one word for every word acknowledgment it receives.

The late-error line is examined two clocks after each acknowledged word, and a transfer is reported complete only once the final word has passed that check. An error acknowledgment, or a late error inside its sampling window, is fatal. The sequencer gives up the bus, answers the current request with an error pulse, raises the host interrupt and stops all further data movement until reset. Requests that arrive while it is in this state are accepted and refused at once.

Top module: `dma_bus_master`

## Requirements
- R1: `bus_req` is high only while a request waits for the bus, and never in a cycle where `slave_busy` is high. With `slave_busy` low in that state it stays high until `bus_grant` is seen.
- R2: One clock after a cycle with both `bus_req` and `bus_grant` high, the address phase runs for one cycle. In it `bus_data_oe` is 1, `bus_data_out` carries the request address, and `bus_rd` is 1 for a read and 0 for a write.
- R3: `bus_siz` is 000 for `req_size` 0 or 3 (one word), 100 for `req_size` 1 (16 bytes, four words) and 101 for `req_size` 2 (32 bytes, eight words). It holds that value through the address and data phases.
- R4: In the data phase, each cycle with `bus_ack` = 011 transfers one word. On a write, `wr_take` pulses in that cycle while `bus_data_out` shows `wr_data` with `bus_data_oe` high. On a read, `rd_valid` pulses and `rd_data` equals `bus_data_in`. All other codes, including idle 111, transfer nothing.
- R5: `bus_lerr` is sampled at the second clock edge after the edge that took an acknowledged word, and is ignored at any other time. After the last word, a clean sample produces a one-cycle `resp_done` pulse just after that edge, and the block becomes ready again.
- R6: `bus_ack` = 110 during the data phase is fatal. After that edge `bus_data_oe` is 0, `resp_err` pulses for one cycle and `irq` is 1.
- R7: A high `bus_lerr` in its sampling window is fatal, with the same outcome as R6, and no `resp_done` is given for that transfer.
- R8: The fatal state lasts until reset. `irq` stays high, `bus_req`, `wr_take` and `rd_valid` stay low, and every accepted request receives a `resp_err` pulse one clock later.
- R9: After reset `req_ready` is 1, while `bus_req`, `bus_data_oe`, `irq`, `resp_done` and `resp_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Engine request strobe |
| req_write | input | 1 | 1 = write to host memory, 0 = read |
| req_size | input | 2 | Burst length select |
| req_addr | input | DW | Start address |
| req_ready | output | 1 | Request is taken in this cycle |
| resp_done | output | 1 | Transfer finished cleanly |
| resp_err | output | 1 | Transfer failed or was refused |
| wr_data | input | DW | Word to write for the current beat |
| wr_take | output | 1 | Write word consumed |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | Read word valid |
| slave_busy | input | 1 | A slave access is in progress |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_siz | output | 3 | Transfer size code |
| bus_rd | output | 1 | Direction, 1 = read |
| bus_data_out | output | DW | Data lines when driving |
| bus_data_oe | output | 1 | Data line drive enable |
| bus_data_in | input | DW | Data lines as received |
| bus_ack | input | 3 | Acknowledgment code |
| bus_lerr | input | 1 | Late error |
| irq | output | 1 | Host interrupt |

## Verification
The bench builds the block with its default width, DW = 32. This lets random full-width addresses and data words show any stuck or swapped bit on the address phase and the data paths. Random grant delays, slave-busy stretches and idle acknowledgments between words exercise every burst length in both directions. Directed runs place an error acknowledgment in a random word of a burst, a late error exactly in the window of the final word, and a late error one clock early, which must have no effect.

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_addr,
  output logic          req_ready,
  output logic          resp_done,
  output logic          resp_err,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          slave_busy,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [2:0]    bus_siz,
  output logic          bus_rd,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_data_in,
  input  logic [2:0]    bus_ack,
  input  logic          bus_lerr,
  output logic          irq
);
  localparam logic [2:0] ACK_WORD = 3'b011;
  localparam logic [2:0] ACK_ERR  = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_ADDR, S_DATA, S_LWAIT, S_FATAL} st_t;

  st_t           st;
  logic          wr_q;
  logic [1:0]    siz_q;
  logic [DW-1:0] addr_q;
  logic [3:0]    left_q;
  logic          ack_d1, ack_d2;
  logic          in_data, beat, err_hit, lerr_hit;

  function automatic logic [3:0] beats_of(input logic [1:0] s);
    case (s)
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  assign in_data  = (st == S_DATA);
  assign beat     = in_data && (bus_ack == ACK_WORD);
  assign err_hit  = in_data && (bus_ack == ACK_ERR);
  assign lerr_hit = ack_d2 && bus_lerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr_q      <= 1'b0;
      siz_q     <= 2'd0;
      addr_q    <= '0;
      left_q    <= 4'd0;
      ack_d1    <= 1'b0;
      ack_d2    <= 1'b0;
      resp_done <= 1'b0;
      resp_err  <= 1'b0;
    end else begin
      resp_done <= 1'b0;
      resp_err  <= 1'b0;
      ack_d1    <= beat;
      ack_d2    <= ack_d1;
      if (st != S_FATAL && (err_hit || lerr_hit)) begin
        st       <= S_FATAL;
        resp_err <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            wr_q   <= req_write;
            siz_q  <= req_size;
            addr_q <= req_addr;
            left_q <= beats_of(req_size);
            st     <= S_ARB;
          end
          S_ARB:  if (bus_req && bus_grant) st <= S_ADDR;
          S_ADDR: st <= S_DATA;
          S_DATA: if (beat) begin
            left_q <= left_q - 4'd1;
            if (left_q == 4'd1) st <= S_LWAIT;
          end
          S_LWAIT: if (ack_d2 && !ack_d1) begin
            resp_done <= 1'b1;
            st        <= S_IDLE;
          end
          S_FATAL: if (req_valid) resp_err <= 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign req_ready    = (st == S_IDLE) || (st == S_FATAL);
  assign bus_req      = (st == S_ARB) && !slave_busy;
  assign bus_siz      = (siz_q == 2'd1) ? 3'b100 : (siz_q == 2'd2) ? 3'b101 : 3'b000;
  assign bus_rd       = !wr_q;
  assign bus_data_oe  = (st == S_ADDR) || (in_data && wr_q);
  assign bus_data_out = (st == S_ADDR) ? addr_q : wr_data;
  assign wr_take      = beat && wr_q;
  assign rd_valid     = beat && !wr_q;
  assign rd_data      = bus_data_in;
  assign irq          = (st == S_FATAL);
endmodule

module dma_bus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_grant,
  input logic       slave_busy,
  input logic       bus_data_oe,
  input logic [2:0] bus_siz,
  input logic [2:0] bus_ack,
  input logic       in_data,
  input logic       irq,
  input logic       resp_done,
  input logic       resp_err,
  input logic       wr_take,
  input logic       rd_valid
);
  AST_REQ_NOT_WHILE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !slave_busy); // R1
  AST_GRANT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant) |=> bus_data_oe); // R2
  AST_SIZ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (bus_siz == 3'b000 || bus_siz == 3'b100 || bus_siz == 3'b101)); // R3
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_err)); // R5
  AST_ERR_ACK_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_ack == 3'b110 && !irq) |=> (irq && resp_err && !bus_data_oe)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq); // R8
  AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !(wr_take || rd_valid || bus_req || bus_data_oe)); // R8
endmodule

bind dma_bus_master dma_bus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .slave_busy(slave_busy), .bus_data_oe(bus_data_oe), .bus_siz(bus_siz),
  .bus_ack(bus_ack), .in_data(in_data), .irq(irq), .resp_done(resp_done),
  .resp_err(resp_err), .wr_take(wr_take), .rd_valid(rd_valid)
);

// File: tb/dma_bus_master_bench.sv
`timescale 1ns/100ps
module dma_bus_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, wr_data = 0, bus_data_in = 0;
  logic slave_busy = 0, bus_grant = 0, bus_lerr = 0;
  logic [2:0] bus_ack = 3'b111;
  logic req_ready, resp_done, resp_err, wr_take, rd_valid, bus_req, bus_rd, bus_data_oe, irq;
  logic [31:0] rd_data, bus_data_out;
  logic [2:0] bus_siz;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_bus_master #(.DW(32)) u_dma_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_ready(req_ready),
    .resp_done(resp_done), .resp_err(resp_err), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .slave_busy(slave_busy), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_siz(bus_siz), .bus_rd(bus_rd), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in), .bus_ack(bus_ack),
    .bus_lerr(bus_lerr), .irq(irq));

  function automatic logic [2:0] exp_siz(input logic [1:0] s);
    return (s == 2'd1) ? 3'b100 : (s == 2'd2) ? 3'b101 : 3'b000;
  endfunction
  function automatic int exp_beats(input logic [1:0] s);
    return (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 1;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at %0t: actual %h expected %h", r, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready && !bus_req && !bus_data_oe && !irq && !resp_done && !resp_err, "R9",
        {26'd0, req_ready, bus_req, bus_data_oe, irq, resp_done, resp_err}, 32'h20);
  endtask

  // mode 0 clean, 1 error ack at a random beat, 2 late error in window, 3 late error too early
  task automatic run_txn(input bit wr, input logic [1:0] sz, input logic [31:0] a, input int mode);
    int nb = exp_beats(sz);
    int eb = $urandom_range(0, nb - 1);
    logic [31:0] wd, rv;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < int'($urandom_range(0, 2)); i++) begin
      slave_busy = 1; #1;
      chk(!bus_req, "R1 busy", {31'd0, bus_req}, 0);
      @(negedge clk);
    end
    slave_busy = 0;
    for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
      #1 chk(bus_req, "R1 wait", {31'd0, bus_req}, 1);
      @(negedge clk);
    end
    bus_grant = 1; #1;
    chk(bus_req, "R1 grant", {31'd0, bus_req}, 1);
    @(negedge clk);
    bus_grant = 0; #1;
    chk(bus_data_oe && bus_data_out == a, "R2 addr", bus_data_out, a);
    chk(bus_rd == !wr, "R2 dir", {31'd0, bus_rd}, {31'd0, !wr});
    chk(bus_siz == exp_siz(sz), "R3 siz", {29'd0, bus_siz}, {29'd0, exp_siz(sz)});
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
        bus_ack = 3'b111; #1;
        chk(!wr_take && !rd_valid, "R4 idle", {30'd0, wr_take, rd_valid}, 0);
        chk(bus_siz == exp_siz(sz), "R3 hold", {29'd0, bus_siz}, {29'd0, exp_siz(sz)});
        @(negedge clk);
      end
      if (mode == 1 && b == eb) begin
        bus_ack = 3'b110;
        @(negedge clk);
        bus_ack = 3'b111; #1;
        chk(resp_err && irq && !bus_data_oe, "R6 fatal", {29'd0, resp_err, irq, bus_data_oe}, 32'h6);
        return;
      end
      wd = $urandom; rv = $urandom;
      wr_data = wd; bus_data_in = rv; bus_ack = 3'b011; #1;
      if (wr) chk(wr_take && bus_data_oe && bus_data_out == wd, "R4 wr", bus_data_out, wd);
      else    chk(rd_valid && !wr_take && rd_data == rv, "R4 rd", rd_data, rv);
      @(negedge clk);
    end
    bus_ack = 3'b111;
    bus_lerr = (mode == 3); #1;
    chk(!resp_done, "R5 early", {31'd0, resp_done}, 0);
    @(negedge clk);
    bus_lerr = (mode == 2);
    @(negedge clk);
    bus_lerr = 0; #1;
    if (mode == 2)
      chk(resp_err && irq && !resp_done, "R7 lerr", {29'd0, resp_err, irq, resp_done}, 32'h6);
    else
      chk(resp_done && !resp_err && !irq && req_ready, "R5 done",
          {28'd0, resp_done, resp_err, irq, req_ready}, 32'h9);
  endtask

  task automatic refuse();
    @(negedge clk);
    req_valid = 1; req_write = 1; req_size = 2'd2; req_addr = $urandom; #1;
    chk(req_ready, "R8 ready", {31'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0; #1;
    chk(resp_err && irq && !bus_req, "R8 refuse", {29'd0, resp_err, irq, bus_req}, 32'h6);
    @(negedge clk); #1;
    chk(!resp_err && irq && !bus_req && !wr_take, "R8 sticky", {29'd0, resp_err, irq, bus_req}, 32'h2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    for (int s = 0; s < 4; s++) begin
      run_txn(1'b1, 2'(s), $urandom, 0);
      run_txn(1'b0, 2'(s), $urandom, 0);
    end
    run_txn(1'b1, 2'd0, 32'hFFFF_FFFC, 3);
    run_txn(1'b0, 2'd0, 32'h0000_0004, 3);
    for (int n = 0; n < 40; n++)
      run_txn(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom, 0);
    run_txn(1'b1, 2'd2, 32'hA5A5_0000, 1);
    refuse();
    do_reset();
    run_txn(1'b0, 2'd1, 32'h1234_5670, 0);
    run_txn(1'b0, 2'd2, 32'h0BAD_F00C, 2);
    refuse();
    do_reset();
    run_txn(1'b1, 2'd1, 32'h5555_AAAA, 2);
    refuse();
    do_reset();
    run_txn(1'b0, 2'd0, 32'hDEAD_BEE0, 1);
    refuse();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule